// File: doc/BRIEF.md
# Double-Rate Word Serializer with Forwarded Clock

This block sits between a wide core-side datapath and a narrow source-synchronous output bus. On each group boundary it takes a group of 16-bit words, each with a one-bit control flag. It then sends those words one per cycle of its own clock. That clock runs at the word rate, which is twice the forwarded clock frequency, because a word goes out on each edge of the forwarded clock. The number of words in a group, which is the serialization ratio against the core clock, is chosen from 2, 4 or 8. The block raises a take strobe in the cycle where it captures a group. The core side treats that strobe as its clock-enable and presents a fresh group on it.

The forwarded clock is not derived from the fast clock tree. It comes out of a serializing lane built exactly like the data and control lanes. That lane is loaded with a constant alternating 1,0 pattern, so the clock edges have the same register depth as the data and stay aligned with it. The first word of every group is emitted while the forwarded clock is high, so each group starts on a rising edge.

Top module: `ddr_word_ser`

## Requirements
- R1: While `rst_n` is low, `tx_dat_o`, `tx_ctl_o` and `tx_clk_o` are all 0.
- R2: `take_o` is high in the first cycle after reset release and then exactly once every N cycles, where N is the ratio captured at the previous take.
- R3: The ratio code `ratio_sel_i` decodes as 2'b00 to 2 words, 2'b01 to 4 words, 2'b10 to 8 words and 2'b11 to 8 words.
- R4: `ratio_sel_i` is sampled only in a cycle where `take_o` is high; values it holds in other cycles have no effect.
- R5: A group captured on a take is emitted over the next N cycles, one word per cycle, starting with word 0 (`par_data_i[15:0]`). Word i is taken from `par_data_i[16*i+15:16*i]` and appears i+1 cycles after the capture edge.
- R6: Each word keeps its byte order: the first byte is in bits 15:8 and the second byte is in bits 7:0. Bits 15 and 7 are the MSBs of those bytes.
- R7: The control flag `par_ctl_i[i]` appears on `tx_ctl_o` in the same cycle as word i, with no offset.
- R8: `tx_clk_o` is 1 while the even-index words (0, 2, ...) of a group are on the bus and 0 while the odd-index words are on it, so every group begins on a rising edge.
- R9: Changes to `par_data_i` and `par_ctl_i` in cycles where `take_o` is low do not alter the words being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock (twice the forwarded clock frequency) |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_sel_i | input | 2 | Serialization ratio code, sampled on take |
| par_data_i | input | 128 | Parallel word group, word 0 in the low 16 bits |
| par_ctl_i | input | 8 | Control flag per word, bit i belongs to word i |
| take_o | output | 1 | Group capture strobe (core clock enable) |
| tx_dat_o | output | 16 | Serialized data word |
| tx_ctl_o | output | 1 | Serialized control flag |
| tx_clk_o | output | 1 | Forwarded clock, serialized alternating pattern |

## Verification
The bench sweeps every ratio code, including the duplicate 8-word code, through back-to-back group changes. It drives counting-byte, walking-one, alternating and random words, and checks every emitted word, flag and clock bit against a model that only indexes the group. Between takes it puts random data and random ratio codes on the inputs. If the design sampled the ratio mid-group, it would shorten or stretch a group and the take check would fail. If it read the live input instead of the held group, the emitted words would differ. A word order that is reversed or offset by one fails the word-0-first check. An inverted clock pattern fails the clock check. A lane that is one register shallower or deeper than the others puts the control flag or the clock out of step with the data.

// File: rtl/ddr_word_ser_pkg.sv
package ddr_word_ser_pkg;

    localparam int unsigned WORD_BITS = 16;

    typedef enum logic [1:0] {
        RATIO_X2  = 2'b00,
        RATIO_X4  = 2'b01,
        RATIO_X8  = 2'b10,
        RATIO_X8B = 2'b11
    } ratio_code_e;

    // Number of words per group for a ratio code.
    function automatic logic [3:0] words_of(input logic [1:0] code);
        logic [3:0] n;
        case (ratio_code_e'(code))
            RATIO_X2: n = 4'd2;
            RATIO_X4: n = 4'd4;
            default:  n = 4'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ser_phase_gen.sv
module ser_phase_gen
    import ddr_word_ser_pkg::*;
#(
    parameter int unsigned MAX_RATIO = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ratio_sel_i,
    output logic       take_o
);
    localparam int unsigned PH_W = (MAX_RATIO > 2) ? $clog2(MAX_RATIO) : 1;
    localparam logic [3:0]  MAX_W = 4'(MAX_RATIO);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic [PH_W-1:0] last;
    } ph_state_t;

    ph_state_t st_d, st_q;
    logic [3:0] words_now;

    always_comb begin
        st_d      = st_q;
        words_now = words_of(ratio_sel_i);
        if (words_now > MAX_W) begin
            words_now = MAX_W;
        end
        if (st_q.phase == '0) begin
            // group boundary: latch the ratio for this group
            st_d.last  = PH_W'(words_now - 4'd1);
            st_d.phase = PH_W'(1);
        end else if (st_q.phase == st_q.last) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + PH_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o = (st_q.phase == '0);

endmodule

// File: rtl/ser_shift_lane.sv
module ser_shift_lane #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [WIDTH*DEPTH-1:0] par_i,
    output logic [WIDTH-1:0]       ser_o
);
    localparam int unsigned TOT_W = WIDTH * DEPTH;

    typedef struct packed {
        logic [TOT_W-1:0] shreg;
        logic [WIDTH-1:0] outw;
    } lane_state_t;

    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            // word 0 goes straight to the output register
            st_d.outw  = par_i[WIDTH-1:0];
            st_d.shreg = par_i >> WIDTH;
        end else begin
            st_d.outw  = st_q.shreg[WIDTH-1:0];
            st_d.shreg = st_q.shreg >> WIDTH;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o = st_q.outw;

endmodule

// File: rtl/ddr_word_ser.sv
module ddr_word_ser
    import ddr_word_ser_pkg::*;
#(
    parameter int unsigned WORD_W    = WORD_BITS,
    parameter int unsigned MAX_RATIO = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  ratio_sel_i,
    input  logic [WORD_W*MAX_RATIO-1:0] par_data_i,
    input  logic [MAX_RATIO-1:0]        par_ctl_i,
    output logic                        take_o,
    output logic [WORD_W-1:0]           tx_dat_o,
    output logic                        tx_ctl_o,
    output logic                        tx_clk_o
);
    logic                 take;
    logic [MAX_RATIO-1:0] clk_pattern;

    // constant 1,0,1,0... with word 0 high
    genvar gi;
    generate
        for (gi = 0; gi < MAX_RATIO; gi++) begin : g_pat
            assign clk_pattern[gi] = ((gi % 2) == 0);
        end
    endgenerate

    ser_phase_gen #(
        .MAX_RATIO (MAX_RATIO)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .ratio_sel_i (ratio_sel_i),
        .take_o      (take)
    );

    ser_shift_lane #(
        .WIDTH (WORD_W),
        .DEPTH (MAX_RATIO)
    ) u_dat_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (take),
        .par_i  (par_data_i),
        .ser_o  (tx_dat_o)
    );

    ser_shift_lane #(
        .WIDTH (1),
        .DEPTH (MAX_RATIO)
    ) u_ctl_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (take),
        .par_i  (par_ctl_i),
        .ser_o  (tx_ctl_o)
    );

    ser_shift_lane #(
        .WIDTH (1),
        .DEPTH (MAX_RATIO)
    ) u_clk_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (take),
        .par_i  (clk_pattern),
        .ser_o  (tx_clk_o)
    );

    assign take_o = take;

endmodule

// File: rtl/ddr_word_ser_chk.sv
module ddr_word_ser_chk #(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned MAX_RATIO = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [1:0]                  ratio_sel_i,
    input logic [WORD_W*MAX_RATIO-1:0] par_data_i,
    input logic [MAX_RATIO-1:0]        par_ctl_i,
    input logic                        take_o,
    input logic [WORD_W-1:0]           tx_dat_o,
    input logic                        tx_ctl_o,
    input logic                        tx_clk_o
);
    logic       seen_q;
    logic [3:0] gap_q;
    logic [3:0] want_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
            want_q <= '0;
        end else begin
            if (take_o) begin
                seen_q <= 1'b1;
                gap_q  <= 4'd1;
                want_q <= (ratio_sel_i == 2'b00) ? 4'd2 :
                          (ratio_sel_i == 2'b01) ? 4'd4 : 4'd8;
            end else if (gap_q != 4'hF) begin
                gap_q <= gap_q + 4'd1;
            end
        end
    end

    // R2
    take_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && seen_q) |-> (gap_q == want_q));

    // R5
    word0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (tx_dat_o == $past(par_data_i[WORD_W-1:0])));

    // R7
    ctl_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (tx_ctl_o == $past(par_ctl_i[0])));

    // R8
    rise_on_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> tx_clk_o);

    // R8
    clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |=> (tx_clk_o != $past(tx_clk_o)));

    // R1
    always @(negedge clk) begin
        if (!rst_n && seen_q == 1'b0 && $time > 0) begin
            reset_quiet_chk: assert (tx_clk_o == 1'b0 || $isunknown(tx_clk_o));
        end
    end

endmodule

bind ddr_word_ser ddr_word_ser_chk #(
    .WORD_W    (WORD_W),
    .MAX_RATIO (MAX_RATIO)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ratio_sel_i (ratio_sel_i),
    .par_data_i  (par_data_i),
    .par_ctl_i   (par_ctl_i),
    .take_o      (take_o),
    .tx_dat_o    (tx_dat_o),
    .tx_ctl_o    (tx_ctl_o),
    .tx_clk_o    (tx_clk_o)
);

// File: tb/sim_ddr_word_ser.sv
module sim_ddr_word_ser;
    localparam int W = 16;
    localparam int M = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     ratio_sel = '0;
    logic [W*M-1:0] par_data = '0;
    logic [M-1:0]   par_ctl = '0;
    logic           take;
    logic [W-1:0]   tx_dat;
    logic           tx_ctl;
    logic           tx_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    ddr_word_ser #(.WORD_W(W), .MAX_RATIO(M)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ratio_sel_i (ratio_sel),
        .par_data_i  (par_data),
        .par_ctl_i   (par_ctl),
        .take_o      (take),
        .tx_dat_o    (tx_dat),
        .tx_ctl_o    (tx_ctl),
        .tx_clk_o    (tx_clk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W*M-1:0] rand_wide();
        logic [W*M-1:0] v;
        for (int k = 0; k < (W*M)/32; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    function automatic int words_of(input logic [1:0] c);
        return (c == 2'b00) ? 2 : (c == 2'b01) ? 4 : 8;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W*M-1:0] grp;
        logic [M-1:0]   gctl;
        int             gratio;
        int             bidx;
        int             gnum;
        bit             exp_valid;
        logic [W-1:0]   e_dat;
        logic           e_ctl;
        logic           e_clk;

        bidx = 0; gnum = 0; exp_valid = 0; gratio = 2;
        grp = '0; gctl = '0; e_dat = '0; e_ctl = 0; e_clk = 0;

        // R1: outputs quiet in reset, even with busy inputs
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            par_data = rand_wide();
            par_ctl  = M'($urandom);
            if (r > 0) begin
                chk("R1 dat", 32'(tx_dat), 32'h0);
                chk("R1 ctl", 32'(tx_ctl), 32'h0);
                chk("R1 clk", 32'(tx_clk), 32'h0);
            end
        end

        for (int s = 0; s < 6000; s++) begin
            @(negedge clk);
            if (s == 0) rst_n = 1'b1;
            if (exp_valid) begin
                // R5 R9: word order and held group
                chk("R5/R9 word", 32'(tx_dat), 32'(e_dat));
                // R6: first byte in the high half
                chk("R6 first byte", 32'(tx_dat[15:8]), 32'(e_dat[15:8]));
                chk("R7 ctl", 32'(tx_ctl), 32'(e_ctl));
                chk("R8 clk", 32'(tx_clk), 32'(e_clk));
            end
            // R2 R3: take period follows the decoded ratio
            chk("R2/R3 take", 32'(take), 32'(bidx == 0));
            if (bidx == 0) begin
                logic [1:0] code;
                int mode;
                code = (gnum < 64) ? 2'((gnum / 4) % 4) : 2'($urandom % 4);
                mode = gnum % 4;
                for (int i = 0; i < M; i++) begin
                    case (mode)
                        0: grp[W*i +: W] = {8'(gnum * 16 + 2 * i), 8'(gnum * 16 + 2 * i + 1)};
                        1: grp[W*i +: W] = 16'h1 << ((gnum + i) % 16);
                        2: grp[W*i +: W] = (i % 2 == 0) ? 16'hFFFF : 16'h0000;
                        default: grp[W*i +: W] = 16'($urandom);
                    endcase
                    gctl[i] = (mode == 2) ? (i % 2 == 1) : 1'($urandom);
                end
                ratio_sel = code;
                par_data  = grp;
                par_ctl   = gctl;
                gratio    = words_of(code);
                gnum++;
            end else begin
                // R4 R9: noise between takes must be ignored
                ratio_sel = 2'($urandom);
                par_data  = rand_wide();
                par_ctl   = M'($urandom);
            end
            e_dat = grp[W*bidx +: W];
            e_ctl = gctl[bidx];
            e_clk = (bidx % 2 == 0);
            exp_valid = 1;
            bidx = (bidx + 1 == gratio) ? 0 : bidx + 1;
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule